// File: doc/BRIEF.md
# RGBA to 18-bit Pixel Row Streamer

This block turns a rectangle of 32-bit RGBA pixels into the byte stream that a colour display controller expects on a four-wire serial link. Each pixel becomes three bytes of 6-bit colour. A single `start` pulse carries the request: the column window, the row window, the first source byte address, the row stride in bytes, a flag for a panel mounted upside down, and the panel height. The block first emits a fixed setup sequence of command and data bytes. The row addresses in that sequence are shifted when the panel is flipped. The block then walks the source memory row by row and emits the pixel bytes.

Bytes leave through a valid/ready port. `outDc` gives the level of the data/command line for each byte: 0 for a command and 1 for data. The source memory is read through a byte-wide port that answers in the same cycle. The serial shifter that sits after this block is not part of it. A request for the three-wire link cannot be served and is refused, and so is a malformed window. The block reports the end of a stream with `done` and a refusal with `rejected`.

Top module: `rgb18_row_streamer`

## Requirements
- R1: An accepted request emits a 7-byte header before any pixel byte, in this order: command 0x75 (outDc=0), start row, end row, command 0x15 (outDc=0), start column, end column, command 0x5C (outDc=0). The four window bytes carry outDc=1.
- R2: When `flip` is 1, both row bytes in the header equal the requested row plus (132 - panelHeight), taken modulo 256. When `flip` is 0 they equal the requested rows unchanged.
- R3: Each pixel occupies 4 source bytes at offsets 0..3 from the pixel address. The block emits source bytes 0, 1 and 2 in that order, each shifted right by 2. Byte 3 never affects the output.
- R4: Every pixel byte has outDc=1 and its bits [7:6] equal 0.
- R5: Each row yields (colEnd - colStart + 1) × 3 pixel bytes. Rows run from rowStart to rowEnd inclusive, so the stream holds 7 + rows × width × 3 bytes in total.
- R6: The first row is read from `srcBase`. Each following row starts `srcStride` bytes after the previous one, and pixels within a row lie 4 bytes apart.
- R7: A request with `threeWire`=1 is refused: `rejected` is 1 in the cycle after `start` and no byte is offered.
- R8: A window wider than 160 pixels, or one with colEnd < colStart or rowEnd < rowStart, is refused the same way. A window of exactly 160 pixels is accepted.
- R9: While outValid=1 and outReady=0, outValid, outByte and outDc hold their values. Under any stall pattern no source byte is skipped or repeated.
- R10: `done` is 1 for one cycle, in the cycle after the final byte is accepted, and outValid is 0 from that cycle on.
- R11: A `start` pulse that arrives while a stream is in progress has no effect on that stream.
- R12: After reset, outValid, done and rejected are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse; inputs below sampled with it |
| threeWire | input | 1 | Request targets the three-wire link (refused) |
| flip | input | 1 | Panel mounted upside down |
| panelHeight | input | 8 | Visible panel height in rows |
| colStart | input | 8 | First column of the window |
| colEnd | input | 8 | Last column of the window |
| rowStart | input | 8 | First row of the window |
| rowEnd | input | 8 | Last row of the window |
| srcBase | input | 16 | Byte address of the first source pixel |
| srcStride | input | 16 | Byte distance between source rows |
| srcAddr | output | 16 | Source read address |
| srcData | input | 8 | Source byte at srcAddr, same cycle |
| outValid | output | 1 | Output byte offered |
| outReady | input | 1 | Sink accepts the byte |
| outByte | output | 8 | Output byte |
| outDc | output | 1 | 0 command, 1 data |
| done | output | 1 | Stream finished (one cycle) |
| rejected | output | 1 | Request refused (one cycle) |

## Verification
A wrong channel counter shows within the first pixel after the header. The bytes would come out in the wrong order, or an alpha byte would appear where a colour belongs. A bad row base or pixel counter survives one row at most: the first byte of the next row is then taken from the wrong address, or the byte count moves the `done` pulse away from the cycle after the last accepted byte. A header index or window register that went wrong is visible in the first seven bytes. Stalled cycles expose any state that moves without a handshake, because the bytes held during the stall would then differ.

// File: rtl/rgb18_pkg.sv
package rgb18_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_HDR, PH_PIX} phase_e;

  typedef struct packed {
    logic load;
    logic hdrStep;
    logic pixStep;
  } strobe_t;
endpackage

// File: rtl/rgb18_datapath.sv
module rgb18_datapath
  import rgb18_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int COORD_W  = 8,
  parameter int MAX_PIX  = 160,
  parameter int ROW_SPAN = 132,
  parameter logic [7:0] CMD_ROW  = 8'h75,
  parameter logic [7:0] CMD_COL  = 8'h15,
  parameter logic [7:0] CMD_WRAM = 8'h5C
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobe,
  input  phase_e             phase,
  input  logic               flip,
  input  logic [COORD_W-1:0] panelHeight,
  input  logic [COORD_W-1:0] colStart,
  input  logic [COORD_W-1:0] colEnd,
  input  logic [COORD_W-1:0] rowStart,
  input  logic [COORD_W-1:0] rowEnd,
  input  logic [ADDR_W-1:0]  srcBase,
  input  logic [ADDR_W-1:0]  srcStride,
  input  logic [7:0]         srcData,
  output logic [ADDR_W-1:0]  srcAddr,
  output logic [7:0]         outByte,
  output logic               outDc,
  output logic               hdrLast,
  output logic               finalByte
);
  localparam int PIX_W   = $clog2(MAX_PIX);
  localparam int HDR_LEN = 7;
  localparam int HDR_W   = $clog2(HDR_LEN);

  logic [COORD_W-1:0] colS, colE, rowS, rowE, rowLeft, rowOffset;
  logic [PIX_W-1:0]   pixIdx, pixLast;
  logic [1:0]         chan;
  logic [HDR_W-1:0]   hdrIdx;
  logic [ADDR_W-1:0]  rowBase, stride;

  assign rowOffset = flip ? (COORD_W'(ROW_SPAN) - panelHeight) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colS <= '0; colE <= '0; rowS <= '0; rowE <= '0; rowLeft <= '0;
      pixIdx <= '0; pixLast <= '0; chan <= '0; hdrIdx <= '0;
      rowBase <= '0; stride <= '0;
    end else if (strobe.load) begin
      colS    <= colStart;
      colE    <= colEnd;
      rowS    <= rowStart + rowOffset;
      rowE    <= rowEnd + rowOffset;
      rowLeft <= rowEnd - rowStart;
      pixLast <= PIX_W'(colEnd - colStart);
      pixIdx  <= '0;
      chan    <= '0;
      hdrIdx  <= '0;
      rowBase <= srcBase;
      stride  <= srcStride;
    end else if (strobe.hdrStep) begin
      hdrIdx <= hdrIdx + 1'b1;
    end else if (strobe.pixStep) begin
      if (chan == 2'd2) begin
        chan <= '0;
        if (pixIdx == pixLast) begin
          pixIdx  <= '0;
          rowBase <= rowBase + stride;
          rowLeft <= rowLeft - 1'b1;
        end else begin
          pixIdx <= pixIdx + 1'b1;
        end
      end else begin
        chan <= chan + 1'b1;
      end
    end
  end

  assign srcAddr   = rowBase + ADDR_W'({pixIdx, 2'b00}) + ADDR_W'(chan);
  assign hdrLast   = (hdrIdx == HDR_W'(HDR_LEN - 1));
  assign finalByte = (chan == 2'd2) && (pixIdx == pixLast) && (rowLeft == '0);

  always_comb begin
    outByte = '0;
    outDc   = 1'b0;
    if (phase == PH_PIX) begin
      outByte = {2'b00, srcData[7:2]};
      outDc   = 1'b1;
    end else if (phase == PH_HDR) begin
      outDc = 1'b1;
      case (hdrIdx)
        3'd0: begin outByte = CMD_ROW;  outDc = 1'b0; end
        3'd1: outByte = 8'(rowS);
        3'd2: outByte = 8'(rowE);
        3'd3: begin outByte = CMD_COL;  outDc = 1'b0; end
        3'd4: outByte = 8'(colS);
        3'd5: outByte = 8'(colE);
        default: begin outByte = CMD_WRAM; outDc = 1'b0; end
      endcase
    end
  end
endmodule

// File: rtl/rgb18_control.sv
module rgb18_control
  import rgb18_pkg::*;
#(
  parameter int COORD_W = 8,
  parameter int MAX_PIX = 160
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               threeWire,
  input  logic [COORD_W-1:0] colStart,
  input  logic [COORD_W-1:0] colEnd,
  input  logic [COORD_W-1:0] rowStart,
  input  logic [COORD_W-1:0] rowEnd,
  input  logic               outReady,
  input  logic               hdrLast,
  input  logic               finalByte,
  output phase_e             phase,
  output strobe_t            strobe,
  output logic               outValid,
  output logic               done,
  output logic               rejected
);
  localparam int SPAN_W = COORD_W + 1;

  logic [SPAN_W-1:0] colSpan;
  logic badReq, xfer;

  assign colSpan  = {1'b0, colEnd} - {1'b0, colStart};
  assign badReq   = threeWire || (colEnd < colStart) || (rowEnd < rowStart) ||
                    (colSpan >= SPAN_W'(MAX_PIX));
  assign outValid = (phase != PH_IDLE);
  assign xfer     = outValid && outReady;

  always_comb begin
    strobe.load    = (phase == PH_IDLE) && start && !badReq;
    strobe.hdrStep = (phase == PH_HDR) && xfer;
    strobe.pixStep = (phase == PH_PIX) && xfer;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      done     <= 1'b0;
      rejected <= 1'b0;
    end else begin
      done     <= 1'b0;
      rejected <= 1'b0;
      case (phase)
        PH_IDLE: if (start) begin
          if (badReq) rejected <= 1'b1;
          else        phase <= PH_HDR;
        end
        PH_HDR: if (xfer && hdrLast) phase <= PH_PIX;
        PH_PIX: if (xfer && finalByte) begin
          phase <= PH_IDLE;
          done  <= 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rgb18_row_streamer.sv
module rgb18_row_streamer
  import rgb18_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int COORD_W  = 8,
  parameter int MAX_PIX  = 160,
  parameter int ROW_SPAN = 132,
  parameter logic [7:0] CMD_ROW  = 8'h75,
  parameter logic [7:0] CMD_COL  = 8'h15,
  parameter logic [7:0] CMD_WRAM = 8'h5C
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               threeWire,
  input  logic               flip,
  input  logic [COORD_W-1:0] panelHeight,
  input  logic [COORD_W-1:0] colStart,
  input  logic [COORD_W-1:0] colEnd,
  input  logic [COORD_W-1:0] rowStart,
  input  logic [COORD_W-1:0] rowEnd,
  input  logic [ADDR_W-1:0]  srcBase,
  input  logic [ADDR_W-1:0]  srcStride,
  output logic [ADDR_W-1:0]  srcAddr,
  input  logic [7:0]         srcData,
  output logic               outValid,
  input  logic               outReady,
  output logic [7:0]         outByte,
  output logic               outDc,
  output logic               done,
  output logic               rejected
);
  phase_e  phase;
  strobe_t strobe;
  logic    hdrLast, finalByte;

  rgb18_control #(.COORD_W(COORD_W), .MAX_PIX(MAX_PIX)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .threeWire(threeWire),
    .colStart(colStart), .colEnd(colEnd), .rowStart(rowStart), .rowEnd(rowEnd),
    .outReady(outReady), .hdrLast(hdrLast), .finalByte(finalByte),
    .phase(phase), .strobe(strobe), .outValid(outValid),
    .done(done), .rejected(rejected)
  );

  rgb18_datapath #(
    .ADDR_W(ADDR_W), .COORD_W(COORD_W), .MAX_PIX(MAX_PIX), .ROW_SPAN(ROW_SPAN),
    .CMD_ROW(CMD_ROW), .CMD_COL(CMD_COL), .CMD_WRAM(CMD_WRAM)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .phase(phase), .flip(flip),
    .panelHeight(panelHeight), .colStart(colStart), .colEnd(colEnd),
    .rowStart(rowStart), .rowEnd(rowEnd), .srcBase(srcBase), .srcStride(srcStride),
    .srcData(srcData), .srcAddr(srcAddr), .outByte(outByte), .outDc(outDc),
    .hdrLast(hdrLast), .finalByte(finalByte)
  );
endmodule

// File: rtl/rgb18_row_streamer_chk.sv
module rgb18_row_streamer_chk #(
  parameter logic [7:0] CMD_ROW  = 8'h75,
  parameter logic [7:0] CMD_WRAM = 8'h5C
) (
  input logic       clk,
  input logic       rstN,
  input logic       outValid,
  input logic       outReady,
  input logic [7:0] outByte,
  input logic       outDc,
  input logic       done,
  input logic       rejected
);
  logic inPix;

  always_ff @(posedge clk) begin
    if (!rstN) inPix <= 1'b0;
    else if (outValid && outReady && !outDc && outByte == CMD_WRAM) inPix <= 1'b1;
    else if (done) inPix <= 1'b0;
  end

  assert_stream_opens_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> (!outDc && outByte == CMD_ROW));

  assert_pix_narrow_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inPix && outValid) |-> (outDc && outByte[7:6] == 2'b00));

  assert_refuse_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    rejected |-> !outValid);

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outByte) && $stable(outDc)));

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!outValid && !rejected));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

bind rgb18_row_streamer rgb18_row_streamer_chk #(.CMD_ROW(CMD_ROW), .CMD_WRAM(CMD_WRAM))
  uChk (.clk(clk), .rstN(rstN), .outValid(outValid), .outReady(outReady),
        .outByte(outByte), .outDc(outDc), .done(done), .rejected(rejected));

// File: tb/sim_rgb18_row_streamer.sv
`timescale 1ns/1ps
module sim_rgb18_row_streamer;
  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, threeWire = 1'b0, flip = 1'b0;
  logic [7:0] panelHeight = 8'd128, colStart = '0, colEnd = '0, rowStart = '0, rowEnd = '0;
  logic [15:0] srcBase = '0, srcStride = '0, srcAddr;
  logic [7:0] srcData, outByte;
  logic outValid, outReady = 1'b0, outDc, done, rejected;

  int checks = 0, failures = 0;
  logic [7:0] mem [0:4095];
  logic [7:0] expByte [0:1023];
  logic       expDc   [0:1023];
  logic [7:0] gotByte [0:1023];
  logic       gotDc   [0:1023];
  int expN, gotN;

  always #2 clk = ~clk;
  assign srcData = mem[srcAddr[11:0]];

  rgb18_row_streamer u0 (
    .clk(clk), .rstN(rstN), .start(start), .threeWire(threeWire), .flip(flip),
    .panelHeight(panelHeight), .colStart(colStart), .colEnd(colEnd),
    .rowStart(rowStart), .rowEnd(rowEnd), .srcBase(srcBase), .srcStride(srcStride),
    .srcAddr(srcAddr), .srcData(srcData), .outValid(outValid), .outReady(outReady),
    .outByte(outByte), .outDc(outDc), .done(done), .rejected(rejected)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic buildExpected(input int base, input int stride, input int c0, input int c1,
                               input int r0, input int r1, input bit fl, input int ph);
    int off;
    off = fl ? (132 - ph) : 0;
    expByte[0] = 8'h75; expDc[0] = 0;
    expByte[1] = 8'((r0 + off) & 255); expDc[1] = 1;
    expByte[2] = 8'((r1 + off) & 255); expDc[2] = 1;
    expByte[3] = 8'h15; expDc[3] = 0;
    expByte[4] = 8'(c0); expDc[4] = 1;
    expByte[5] = 8'(c1); expDc[5] = 1;
    expByte[6] = 8'h5C; expDc[6] = 0;
    expN = 7;
    for (int r = 0; r <= r1 - r0; r++)
      for (int p = 0; p <= c1 - c0; p++)
        for (int c = 0; c < 3; c++) begin
          expByte[expN] = mem[(base + r * stride + p * 4 + c) & 4095] >> 2;
          expDc[expN] = 1;
          expN++;
        end
  endtask

  // mode 0: always ready, 1: alternate, 2: pseudo-random; poke: start pulse mid-stream
  task automatic runStream(input string name, input int base, input int stride,
                           input int c0, input int c1, input int r0, input int r1,
                           input bit fl, input int ph, input int mode, input bit poke);
    int doneCyc, lastX, stallErr, pixBad;
    bit holdPend, holdDc, hdrOk, pixOk;
    logic [7:0] holdByte;
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    buildExpected(base, stride, c0, c1, r0, r1, fl, ph);
    @(negedge clk);
    srcBase = 16'(base); srcStride = 16'(stride); colStart = 8'(c0); colEnd = 8'(c1);
    rowStart = 8'(r0); rowEnd = 8'(r1); flip = fl; panelHeight = 8'(ph); threeWire = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    gotN = 0; doneCyc = -1; lastX = -1; stallErr = 0; holdPend = 0;
    for (int cyc = 0; cyc < 6000; cyc++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      outReady = (mode == 0) ? 1'b1 : (mode == 1) ? cyc[0] : lfsr[0];
      if (poke && cyc == 4) begin
        start = 1; colStart = 8'd0; colEnd = 8'd9; rowStart = 8'd0; rowEnd = 8'd9;
        srcBase = 16'd0; flip = ~fl;
      end
      if (poke && cyc == 5) start = 0;
      #1;
      if (done) begin doneCyc = cyc; break; end
      if (holdPend && !(outValid && outByte == holdByte && outDc == holdDc)) stallErr++;
      holdPend = 0;
      if (outValid && outReady) begin
        if (gotN < 1024) begin gotByte[gotN] = outByte; gotDc[gotN] = outDc; end
        gotN++; lastX = cyc;
      end else if (outValid) begin
        holdPend = 1; holdByte = outByte; holdDc = outDc;
      end
      @(negedge clk);
    end
    check(gotN == expN, "R5", {name, " byte count"}, gotN, expN);
    hdrOk = 1;
    for (int i = 0; i < 7; i++)
      if (gotByte[i] !== expByte[i] || gotDc[i] !== expDc[i]) hdrOk = 0;
    check(hdrOk, "R1", {name, " header bytes"}, gotByte[0], expByte[0]);
    if (fl) check(gotByte[1] == expByte[1] && gotByte[2] == expByte[2], "R2",
                  {name, " flipped rows"}, gotByte[1], expByte[1]);
    pixOk = 1; pixBad = 0;
    for (int i = 7; i < expN && i < gotN; i++)
      if (gotByte[i] !== expByte[i]) begin pixOk = 0; pixBad = i; end
    check(pixOk, "R3", {name, " pixel bytes"}, gotByte[pixBad], expByte[pixBad]);
    if (r1 > r0) begin
      int k = 7 + (c1 - c0 + 1) * 3;
      check(gotByte[k] === expByte[k], "R6", {name, " second row start"}, gotByte[k], expByte[k]);
    end
    pixOk = 1;
    for (int i = 7; i < gotN && i < 1024; i++)
      if (gotByte[i][7:6] != 2'b00 || gotDc[i] != 1'b1) pixOk = 0;
    check(pixOk, "R4", {name, " pixel msbs and dc"}, 0, 0);
    check(doneCyc == lastX + 1 && doneCyc >= 0, "R10", {name, " done timing"}, doneCyc, lastX + 1);
    check(!outValid, "R10", {name, " idle at done"}, outValid, 0);
    if (mode != 0) check(stallErr == 0, "R9", {name, " stall hold"}, stallErr, 0);
    if (poke) check(pixOk && gotN == expN, "R11", {name, " start ignored"}, gotN, expN);
    outReady = 0;
    @(negedge clk);
    check(!done, "R10", {name, " done one cycle"}, done, 0);
  endtask

  task automatic runReject(input string req, input string name, input bit tw,
                           input int c0, input int c1, input int r0, input int r1);
    int seen;
    @(negedge clk);
    threeWire = tw; colStart = 8'(c0); colEnd = 8'(c1); rowStart = 8'(r0); rowEnd = 8'(r1);
    start = 1; outReady = 1;
    @(negedge clk);
    start = 0; threeWire = 0;
    #1;
    check(rejected === 1'b1, req, {name, " rejected pulse"}, rejected, 1);
    seen = 0;
    for (int i = 0; i < 4; i++) begin
      if (outValid) seen++;
      @(negedge clk); #1;
    end
    check(seen == 0 && !done, req, {name, " no output"}, seen, 0);
    outReady = 0;
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'((i * 37 + 11) & 255);
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    check(!outValid && !done && !rejected, "R12", "reset state", outValid, 0);
    runStream("basic", 300, 100, 0, 1, 0, 2, 0, 128, 0, 0);
    runStream("flip", 1000, 64, 5, 5, 10, 11, 1, 128, 1, 0);
    runStream("flipwrap", 40, 24, 3, 4, 252, 253, 1, 128, 2, 0);
    runReject("R7", "threewire", 1, 0, 3, 0, 1);
    runReject("R8", "too wide", 0, 0, 160, 0, 0);
    runReject("R8", "reversed cols", 0, 9, 8, 0, 0);
    runReject("R8", "reversed rows", 0, 0, 1, 5, 4);
    runStream("full width R8", 16, 640, 0, 159, 7, 7, 0, 128, 0, 0);
    runStream("stall poke", 2000, 200, 2, 4, 1, 3, 0, 96, 2, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule